// File: doc/BRIEF.md
# Reloadable Watchdog Countdown Timer

This block is a system-management watchdog. Software stores a 10-bit initial value, then arms and re-arms the timer by writing a separate reload register. Each write to the reload register copies the stored value into a down-counter. A free-running prescaler divides the core clock into a coarse tick of about 0.6 s. The counter loses one on each tick while the power-state input reports the full-on state. If software does not reload in time and the counter reaches zero, the block emits a single-cycle timeout pulse and sets a sticky status bit. The surrounding system decides what to do with that event.

The register interface is a plain write strobe, a 2-bit register select, a 16-bit write word and a combinational read word. Select 0 is the initial-value register. Select 1 is the reload register, which accepts any data and reads as zero. Select 2 reads the current count and ignores writes. Select 3 is the status register, whose bit 0 is the sticky timeout flag and is cleared by writing 1. Reads have no side effects.

The counter leaves reset at zero and idle, so the first reload write is what arms it. The tick period is a parameter. By default it is derived from the clock frequency and the tick length in milliseconds, and a bench can override it with a short period.

Top module: `wdt_reload_timer`

## Requirements
- R1: Reading select 0 returns the stored initial value in bits 9:0, and bits 15:10 always read as zero. After reset the stored value is 4.
- R2: A write to select 0 whose bits 9:0 are 0 or 1 is ignored and the previously stored value is kept. Any value from 2 to 1023 is stored.
- R3: A write to select 1 loads the stored initial value into the counter, visible on count_o from the next cycle. Reading select 1 returns zero.
- R4: While the power-state input is high, the counter decreases by exactly one on each prescaler tick, one tick every TICK_CYCLES clocks. A timeout therefore follows a reload of value N after N ticks, give or take one tick period.
- R5: While the power-state input is low, the counter keeps its value on every cycle unless a reload is written.
- R6: When a tick takes the counter from 1 to 0, timeout_pulse_o is high for exactly one cycle. In that same cycle count_o reads 0 and timeout_sts_o is set.
- R7: The status bit stays set until software writes 1 to bit 0 of select 3. Writing 0 there leaves it unchanged. A new timeout in the same cycle as the clear wins.
- R8: After a timeout the counter stays at zero and no further pulse occurs until the next reload. A reload written in the same cycle as a tick loads the initial value and no decrement happens.
- R9: After reset, count_o is 0 and timeout_pulse_o and timeout_sts_o are low. Reading select 2 returns the current count, and repeated reads do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 init, 1 reload, 2 count, 3 status |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| pwr_full_on_i | input | 1 | High while the system is in the full-on power state |
| count_o | output | 10 | Current counter value |
| timeout_pulse_o | output | 1 | One-cycle timeout event |
| timeout_sts_o | output | 1 | Sticky timeout status |

## Verification
Several behaviours are checked on every cycle: the step rule of the counter (it holds or drops by one, never anything else), its freeze outside full-on, its stay at zero, the reload load value, that the stored value is never below 2, the pulse shape and its coincidence with zero count and set status, and the set-over-clear rule of the status bit. Other behaviours need directed scenarios. These include the end-to-end timeout latency in ticks, rejection of the values 0 and 1 seen through readback, the reserved-bit masking, a reload placed exactly on a tick edge, and the side-effect-free count reads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_INIT   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int unsigned MIN_INIT_VAL   = 2;
  localparam int unsigned RESET_INIT_VAL = 4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (div_q == LAST);
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/wdt_init_reg.sv
module wdt_init_reg #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned RESET_VAL = 4,
  parameter int unsigned MIN_VAL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] val_o
);
  logic [CNT_W-1:0] val_q;
  logic             legal;

  // values below MIN_VAL are dropped, old value kept
  assign legal = (wdata_i >= CNT_W'(MIN_VAL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             val_q <= CNT_W'(RESET_VAL);
    else if (wr_i && legal)  val_q <= wdata_i;
  end

  assign val_o = val_q;
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             dec;

  // reload beats the tick; zero is terminal until reload
  assign dec      = !reload_i && tick_i && run_i && (cnt_q != '0);
  assign expire_o = dec && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= expire_o;
      if (reload_i) cnt_q <= load_val_i;
      else if (dec) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/wdt_reload_timer.sv
module wdt_reload_timer #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TICK_MS     = 600,
  parameter int unsigned TICK_CYCLES = (CLK_HZ / 1000) * TICK_MS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             pwr_full_on_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_pulse_o,
  output logic             timeout_sts_o
);
  import wdt_pkg::*;

  localparam int unsigned PAD_W = REG_W - CNT_W;

  reg_sel_e         sel;
  logic             wr_init, wr_reload, wr_status;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] cnt;
  logic             tick, expire, pulse;
  logic             sts_q;
  logic             unused_wdata_hi;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_init   = wr_en_i && (sel == SEL_INIT);
  assign wr_reload = wr_en_i && (sel == SEL_RELOAD);
  assign wr_status = wr_en_i && (sel == SEL_STATUS);
  assign unused_wdata_hi = ^wdata_i[REG_W-1:CNT_W];

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  wdt_init_reg #(
    .CNT_W     (CNT_W),
    .RESET_VAL (RESET_INIT_VAL),
    .MIN_VAL   (MIN_INIT_VAL)
  ) u_init (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_init),
    .wdata_i (wdata_i[CNT_W-1:0]),
    .val_o   (init_val)
  );

  wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (wr_reload),
    .load_val_i (init_val),
    .tick_i     (tick),
    .run_i      (pwr_full_on_i),
    .cnt_o      (cnt),
    .expire_o   (expire),
    .pulse_o    (pulse)
  );

  // sticky flag rises with the pulse; set wins over W1C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sts_q <= 1'b0;
    else if (expire)                  sts_q <= 1'b1;
    else if (wr_status && wdata_i[0]) sts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_INIT:   rdata_o = {{PAD_W{1'b0}}, init_val};
      SEL_RELOAD: rdata_o = '0;
      SEL_COUNT:  rdata_o = {{PAD_W{1'b0}}, cnt};
      SEL_STATUS: rdata_o = {{(REG_W-1){1'b0}}, sts_q};
      default:    rdata_o = '0;
    endcase
  end

  assign count_o         = cnt;
  assign timeout_pulse_o = pulse;
  assign timeout_sts_o   = sts_q;
endmodule

// File: rtl/wdt_reload_timer_chk.sv
module wdt_reload_timer_chk #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             pwr_full_on_i,
  input logic [CNT_W-1:0] count_o,
  input logic             timeout_pulse_o,
  input logic             timeout_sts_o,
  input logic [CNT_W-1:0] init_val
);
  logic rld, clr;
  assign rld = wr_en_i && (addr_i == 2'd1);
  assign clr = wr_en_i && (addr_i == 2'd3) && wdata_i[0];

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[REG_W-1:CNT_W] == '0)); // R1
  AST_INIT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_val >= CNT_W'(2)); // R2
  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld |=> (count_o == $past(init_val))); // R3
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rld |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1)); // R4
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_full_on_i && !rld) |=> $stable(count_o)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_pulse_o |=> !timeout_pulse_o); // R6
  AST_PULSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_pulse_o |-> (count_o == '0) && timeout_sts_o); // R6
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!timeout_sts_o || timeout_pulse_o)); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_sts_o && !clr) |=> timeout_sts_o); // R7
  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((count_o == '0) && !rld) |=> (count_o == '0)); // R8
endmodule

bind wdt_reload_timer wdt_reload_timer_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .rdata_o         (rdata_o),
  .pwr_full_on_i   (pwr_full_on_i),
  .count_o         (count_o),
  .timeout_pulse_o (timeout_pulse_o),
  .timeout_sts_o   (timeout_sts_o),
  .init_val        (init_val)
);

// File: tb/wdt_reload_timer_tb_top.sv
module wdt_reload_timer_tb_top;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwr = 1'b0;
  logic [9:0]  count;
  logic        pulse, sts;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  wdt_reload_timer #(.TICK_CYCLES(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwr_full_on_i(pwr),
    .count_o(count), .timeout_pulse_o(pulse), .timeout_sts_o(sts)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R9 count after reset", count, 0);
    check("R9 pulse after reset", pulse, 0);
    check("R9 status after reset", sts, 0);
    rd(2'd0, d); check("R1 init reset value", d, 4);
  endtask

  task automatic t_init_write();
    logic [15:0] d;
    wr(2'd0, 16'hFC10); rd(2'd0, d); check("R1 reserved bits read zero", d, 16'h0010);
    wr(2'd0, 16'h0000); rd(2'd0, d); check("R2 write of 0 ignored", d, 16'h0010);
    wr(2'd0, 16'h0001); rd(2'd0, d); check("R2 write of 1 ignored", d, 16'h0010);
    wr(2'd0, 16'h0002); rd(2'd0, d); check("R2 write of 2 stored", d, 2);
    wr(2'd0, 16'h03FF); rd(2'd0, d); check("R2 write of 1023 stored", d, 1023);
  endtask

  task automatic t_reload_gate();
    logic [15:0] d;
    pwr = 1'b0;
    wr(2'd0, 16'd20);
    wr(2'd1, 16'hABCD);
    check("R3 reload loads init", count, 20);
    rd(2'd1, d); check("R3 reload reads zero", d, 0);
    repeat (5*T) @(negedge clk);
    check("R5 held while not full-on", count, 20);
    rd(2'd2, d); check("R9 count readback", d, 20);
    rd(2'd2, d); rd(2'd2, d); check("R9 repeated reads no effect", count, 20);
  endtask

  task automatic t_countdown();
    int cyc = 0;
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd0);
    pwr = 1'b1;
    while (!pulse && cyc < 20*T) begin
      @(negedge clk); cyc++;
    end
    check("R4 timeout within one tick (low)", int'(cyc >= 4*T), 1);
    check("R4 timeout within one tick (high)", int'(cyc <= 5*T + 2), 1);
    check("R6 pulse seen", pulse, 1);
    check("R6 count zero at pulse", count, 0);
    check("R6 status set at pulse", sts, 1);
    @(negedge clk);
    check("R6 pulse one cycle", pulse, 0);
    cyc = 0;
    repeat (3*T) begin @(negedge clk); if (pulse) cyc++; end
    check("R8 no repeat pulse", cyc, 0);
    check("R8 count stays zero", count, 0);
  endtask

  task automatic t_w1c();
    wr(2'd3, 16'h0000); check("R7 write 0 keeps status", sts, 1);
    wr(2'd3, 16'h0001); check("R7 write 1 clears status", sts, 0);
  endtask

  task automatic t_reload_on_tick();
    logic [9:0] prev;
    int guard = 0;
    pwr = 1'b1;
    wr(2'd0, 16'd50);
    wr(2'd1, 16'd0);
    prev = count;
    while (count == prev && guard < 4*T) begin @(negedge clk); guard++; end
    check("R4 decrement by one", count, 49);
    repeat (T-1) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 reload beats tick", count, 50);
    repeat (T-1) @(negedge clk);
    check("R8 no decrement before next tick", count, 50);
    @(negedge clk);
    check("R4 next tick decrements", count, 49);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_write();
    t_reload_gate();
    t_countdown();
    t_w1c();
    t_reload_on_tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule